// File: doc/BRIEF.md
# Video Memory Write Spacing Monitor

This block sits beside the CPU port that writes data into a video chip's memory and measures how many CPU clock cycles pass between successive write strobes. Each write is judged against a minimum spacing. That minimum is picked per write from three inputs: the current display mode, whether sprites are on, and whether the beam is in a blanked line. Graphics modes with sprites need the widest spacing. Text and multicolor modes need less. Blanked lines need the least, because no display fetches compete for memory during them.

A write that arrives too soon after the one before it raises a one-cycle violation pulse. It also sets a sticky flag, which holds until a clear input is asserted. The length of the most recent interval is kept on an output so that software or a debug bench can read it. The monitor never stalls or alters the traffic it watches.

Top module: `write_spacing_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `viol_pulse`, `viol_sticky` and `last_interval` all become 0.
- R2: The interval of a write is the number of rising clock edges from the previous strobe to this strobe. Back-to-back strobes give 1. It appears on `last_interval` one cycle after the strobe edge.
- R3: The interval count saturates at 2^CNT_W-1 (63 by default) and does not wrap.
- R4: When `blank` is 1, the minimum spacing is 8 cycles, whatever the mode and sprite setting.
- R5: In graphics modes (`disp_mode` 0 or 1) with `spr_en`=1 and `blank`=0, the minimum spacing is 29 cycles.
- R6: In text mode (`disp_mode` 2) with `blank`=0, the minimum spacing is 12 cycles.
- R7: In multicolor mode (`disp_mode` 3) with `blank`=0, the minimum spacing is 13 cycles.
- R8: In graphics modes with `spr_en`=0 and `blank`=0, the minimum spacing is 8 cycles.
- R9: A write whose interval is below its minimum makes `viol_pulse` high for exactly the cycle after its strobe edge. A write that meets its minimum leaves `viol_pulse` low.
- R10: The first write after reset is never flagged and leaves `last_interval` unchanged.
- R11: `viol_sticky` is set by any violation and stays set until `clr_sticky` is seen high at an edge. When a violation and a clear occur in the same cycle, the flag ends up set.
- R12: The minimum used for a write is chosen from `disp_mode`, `spr_en` and `blank` as sampled on that write's strobe edge only. Their values between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One cycle per video memory data write |
| disp_mode | input | 2 | 0/1 graphics, 2 text, 3 multicolor |
| spr_en | input | 1 | Sprites enabled |
| blank | input | 1 | Current line is blanked |
| clr_sticky | input | 1 | Clears the sticky violation flag |
| viol_pulse | output | 1 | One-cycle pulse per too-early write |
| viol_sticky | output | 1 | Latched violation flag |
| last_interval | output | CNT_W | Cycles between the last two writes, saturated |

## Verification
All three results are registered once, so each one changes on the rising edge that follows the strobe edge. This covers the pulse, the sticky flag and the interval. The bench raises a strobe before a rising edge and reads all three outputs at the falling edge half a cycle after that edge. Between strobes it inverts the mode, sprite and blank inputs, so that a limit taken from the wrong cycle would show up. A sticky clear is applied during an idle cycle and read back at the next falling edge.

// File: rtl/wsm_pkg.sv
// Package: shared types for the write spacing monitor.
// Assumes a two-bit display mode code as listed below.
package wsm_pkg;
    typedef enum logic [1:0] {
        DISP_GFX_A = 2'd0,
        DISP_GFX_B = 2'd1,
        DISP_TEXT  = 2'd2,
        DISP_MULTI = 2'd3
    } disp_mode_e;
endpackage

// File: rtl/wsm_gap_counter.sv
// Counts cycles since the last write strobe, saturating at all-ones.
// Also remembers whether any strobe has been seen since reset.
// Assumes wr_stb is a single-cycle pulse per write.
module wsm_gap_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    output logic [CNT_W-1:0] gap,
    output logic             armed
);
    localparam logic [CNT_W-1:0] GAP_MAX = '1;
    localparam logic [CNT_W-1:0] GAP_ONE = CNT_W'(1);

    // Restart on a strobe, otherwise count up until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= '0;
            armed <= 1'b0;
        end else if (stb) begin
            gap   <= GAP_ONE;
            armed <= 1'b1;
        end else if (gap != GAP_MAX) begin
            gap <= gap + GAP_ONE;
        end
    end

    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == GAP_MAX && !stb) |=> gap == GAP_MAX);
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (gap == GAP_ONE && armed));
endmodule

// File: rtl/wsm_limit_select.sv
// Picks the minimum write spacing from mode, sprite enable and blanking.
// Pure combinational logic; the caller samples it on the strobe edge.
module wsm_limit_select #(
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned LIM_GFX   = 29,
    parameter int unsigned LIM_TEXT  = 12,
    parameter int unsigned LIM_MULTI = 13,
    parameter int unsigned LIM_QUIET = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             spr_en,
    input  logic             blank,
    output logic [CNT_W-1:0] limit
);
    import wsm_pkg::*;

    localparam logic [CNT_W-1:0] L_GFX   = CNT_W'(LIM_GFX);
    localparam logic [CNT_W-1:0] L_TEXT  = CNT_W'(LIM_TEXT);
    localparam logic [CNT_W-1:0] L_MULTI = CNT_W'(LIM_MULTI);
    localparam logic [CNT_W-1:0] L_QUIET = CNT_W'(LIM_QUIET);

    disp_mode_e mode_e;
    assign mode_e = disp_mode_e'(mode);

    // Blanking overrides the mode; graphics without sprites uses the quiet limit.
    always_comb begin
        if (blank) begin
            limit = L_QUIET;
        end else begin
            case (mode_e)
                DISP_GFX_A, DISP_GFX_B: limit = spr_en ? L_GFX : L_QUIET;
                DISP_TEXT:              limit = L_TEXT;
                default:                limit = L_MULTI;
            endcase
        end
    end

    assert_limit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (limit >= L_QUIET) && (limit <= L_GFX));
endmodule

// File: rtl/wsm_judge.sv
// Compares each write's interval with its limit and holds the results.
// Assumes gap and limit are valid in the cycle the strobe is high.
module wsm_judge #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             armed,
    input  logic [CNT_W-1:0] gap,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr,
    output logic             viol_pulse,
    output logic             viol_sticky,
    output logic [CNT_W-1:0] last_gap
);
    logic too_close;
    assign too_close = stb && armed && (gap < limit);

    // Register the pulse, the latched flag (set beats clear) and the interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_pulse  <= 1'b0;
            viol_sticky <= 1'b0;
            last_gap    <= '0;
        end else begin
            viol_pulse <= too_close;
            if (too_close) begin
                viol_sticky <= 1'b1;
            end else if (clr) begin
                viol_sticky <= 1'b0;
            end
            if (stb && armed) begin
                last_gap <= gap;
            end
        end
    end

    assert_pulse_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> $past(stb));
    assert_pulse_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> viol_sticky);
    assert_flag_drop_needs_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(viol_sticky) |-> $past(clr));
    assert_first_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !armed) |=> (!viol_pulse && $stable(last_gap)));
endmodule

// File: rtl/write_spacing_monitor.sv
// Top level: measures strobe-to-strobe spacing of video memory writes
// and flags writes that come sooner than the mode-dependent minimum.
// Assumes all inputs are synchronous to clk.
module write_spacing_monitor #(
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned LIM_GFX   = 29,
    parameter int unsigned LIM_TEXT  = 12,
    parameter int unsigned LIM_MULTI = 13,
    parameter int unsigned LIM_QUIET = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [1:0]       disp_mode,
    input  logic             spr_en,
    input  logic             blank,
    input  logic             clr_sticky,
    output logic             viol_pulse,
    output logic             viol_sticky,
    output logic [CNT_W-1:0] last_interval
);
    logic [CNT_W-1:0] gap;
    logic [CNT_W-1:0] limit;
    logic             armed;

    wsm_gap_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (wr_stb),
        .gap   (gap),
        .armed (armed)
    );

    wsm_limit_select #(
        .CNT_W    (CNT_W),
        .LIM_GFX  (LIM_GFX),
        .LIM_TEXT (LIM_TEXT),
        .LIM_MULTI(LIM_MULTI),
        .LIM_QUIET(LIM_QUIET)
    ) u_limit (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (disp_mode),
        .spr_en (spr_en),
        .blank  (blank),
        .limit  (limit)
    );

    wsm_judge #(.CNT_W(CNT_W)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (wr_stb),
        .armed       (armed),
        .gap         (gap),
        .limit       (limit),
        .clr         (clr_sticky),
        .viol_pulse  (viol_pulse),
        .viol_sticky (viol_sticky),
        .last_gap    (last_interval)
    );
endmodule

// File: tb/test_write_spacing_monitor.sv
`timescale 1ns/1ps
module test_write_spacing_monitor;
    localparam int CW = 6;
    localparam int SAT = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [1:0]    disp_mode = 2'd0;
    logic          spr_en = 1'b0;
    logic          blank = 1'b0;
    logic          clr_sticky = 1'b0;
    logic          viol_pulse;
    logic          viol_sticky;
    logic [CW-1:0] last_interval;

    int checks = 0;
    int fails = 0;
    bit exp_sticky = 1'b0;

    always #2.5 clk = ~clk;

    write_spacing_monitor #(.CNT_W(CW)) i_write_spacing_monitor (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .disp_mode(disp_mode),
        .spr_en(spr_en), .blank(blank), .clr_sticky(clr_sticky),
        .viol_pulse(viol_pulse), .viol_sticky(viol_sticky),
        .last_interval(last_interval)
    );

    function automatic int lim_of(int m, bit s, bit b);
        if (b) return 8;                 // R4
        if (m == 2) return 12;           // R6
        if (m == 3) return 13;           // R7
        return s ? 29 : 8;               // R5 / R8
    endfunction

    function automatic string tag_of(int m, bit s, bit b);
        if (b) return "R4";
        if (m == 2) return "R6";
        if (m == 3) return "R7";
        return s ? "R5" : "R8";
    endfunction

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    // Next strobe lands 'gap' edges after the previous one; configuration
    // is inverted on idle cycles (R12). clr_mode: 1 = clear on first idle, 2 = clear with strobe.
    task automatic issue(int gap, int m, bit s, bit b, int clr_mode);
        int eff;
        bit v;
        wr_stb = 1'b0;
        disp_mode = 2'(3 - m);
        spr_en = !s;
        blank = !b;
        for (int i = 1; i < gap; i++) begin
            clr_sticky = (clr_mode == 1 && i == 1);
            @(posedge clk);
            @(negedge clk);
            if (clr_sticky) begin
                clr_sticky = 1'b0;
                exp_sticky = 1'b0;
                check("R11 clear", viol_sticky, 0);
            end
        end
        wr_stb = 1'b1;
        disp_mode = 2'(m);
        spr_en = s;
        blank = b;
        clr_sticky = (clr_mode == 2);
        @(posedge clk);
        @(negedge clk);
        clr_sticky = 1'b0;
        eff = (gap > SAT) ? SAT : gap;
        v = eff < lim_of(m, s, b);
        if (v) exp_sticky = 1'b1;
        else if (clr_mode == 2) exp_sticky = 1'b0;
        check({tag_of(m, s, b), " R9 R12 pulse"}, viol_pulse, v);
        check("R2 R3 interval", last_interval, eff);
        check("R11 sticky", viol_sticky, exp_sticky);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pulse", viol_pulse, 0);
        check("R1 sticky", viol_sticky, 0);
        check("R1 interval", last_interval, 0);
        rst_n = 1'b1;
        // R10: first write right after reset, counter still at zero
        wr_stb = 1'b1;
        disp_mode = 2'd2;
        @(posedge clk);
        @(negedge clk);
        check("R10 pulse", viol_pulse, 0);
        check("R10 interval", last_interval, 0);
        check("R10 sticky", viol_sticky, 0);
        issue(3, 2, 1'b0, 1'b0, 0);
        // Sweep all configurations across intervals around every limit
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int b = 0; b < 2; b++)
                    for (int g = 1; g <= 34; g++)
                        issue(g, m, s[0], b[0], (g == 20) ? 1 : 0);
        // R3 saturation
        issue(63, 0, 1'b1, 1'b0, 0);
        issue(64, 0, 1'b1, 1'b0, 0);
        issue(100, 3, 1'b0, 1'b0, 0);
        // R11 clear coincident with violation keeps the flag set, and with a pass clears it
        issue(5, 2, 1'b0, 1'b0, 1);
        issue(4, 1, 1'b1, 1'b0, 2);
        issue(30, 1, 1'b1, 1'b0, 2);
        // R1 reset mid-run after a violation
        issue(2, 3, 1'b0, 1'b0, 0);
        rst_n = 1'b0;
        wr_stb = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 pulse again", viol_pulse, 0);
        check("R1 sticky again", viol_sticky, 0);
        check("R1 interval again", last_interval, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule